// File: doc/BRIEF.md
# SECDED-Protected 64-bit Memory

This block is a 64-bit-wide memory with single-error correction and double-error detection built in. Each written word is turned into a 72-bit codeword: 64 data bits, 7 position check bits and one overall parity bit, all of them stored. On a read, the codeword is checked. A single flipped bit is repaired on the output path only, and the copy held in the array is left as it was. Two flipped bits are reported and not repaired.

Each read returns a one-cycle status pulse for a corrected error and another for an uncorrectable error. The address of the most recent read that found an error is kept in a register. A test control can damage a word as it is written. It can flip one data bit, two data bits, or one check bit, so that every path through the decoder can be exercised on purpose.

The array is an inferred RAM with a registered read port. Read data and status are registered once more after decoding. A read issued on one clock edge therefore returns its results on the second edge after it.

Top module: `secded_mem`

## Requirements
- R1: A read issued with `rd_en` high at clock edge N presents `rd_valid` high and the decoded word on `rd_data` after edge N+2. A word written with no injection reads back unchanged, with both error flags low.
- R2: With `inj_mode`=1, the data bit numbered `inj_sel_a` (0 = LSB of `wr_data`) is flipped in the stored codeword. The read returns the original data with `err_single`=1 and `err_double`=0.
- R3: With `inj_mode`=3, one check bit is flipped. `inj_sel_a[2:0]` values 0 to 6 pick position check bit 0 to 6, and 7 picks the overall parity bit. The read sets `err_single`=1 and returns the written data unaltered.
- R4: With `inj_mode`=2 and `inj_sel_a`≠`inj_sel_b`, both data bits are flipped. The read sets `err_double`=1 and `err_single`=0.
- R5: Correction never writes back. Reading a damaged word again flags the same error again.
- R6: On a read whose result raises either error flag, `err_addr` takes that read's address. It holds that value through clean reads and idle cycles until the next errored read.
- R7: `err_single` and `err_double` are never high together, and they are high only in a cycle where `rd_valid` is high. `rd_valid` falls in the cycle after a result, and `rd_data` then keeps its last value.
- R8: `inj_mode`=0 stores a clean codeword whatever the select inputs hold. `inj_mode`=2 with `inj_sel_a`=`inj_sel_b` also stores a clean codeword, because the two flips cancel.
- R9: While `rst` is high at a clock edge, `rd_valid`, `err_single`, `err_double`, `err_addr` and `rd_data` become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 64 | Write data |
| inj_mode | input | 2 | 0 none, 1 one data bit, 2 two data bits, 3 one check bit |
| inj_sel_a | input | 6 | First bit select for injection |
| inj_sel_b | input | 6 | Second data bit select (mode 2) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 64 | Corrected read data |
| err_single | output | 1 | Corrected single-bit error on this result |
| err_double | output | 1 | Uncorrectable double-bit error on this result |
| err_addr | output | ADDR_W | Address of the latest errored read |

## Verification
Every one of the 64 data bit positions is damaged singly and read back. This shows that each position maps to a distinct, correctable syndrome. Each of the 8 check bits is damaged on its own, which separates a fault in the check bits from a fault in the data. All 2016 unordered pairs of data bits are damaged. A pair whose syndrome aliases to a single error would show up as a miscorrection instead of a double flag. Repeated reads, clean reads between errored ones, and equal-select double injection tell write-back, address capture and cancelling flips apart.

// File: rtl/secded_pkg.sv
package secded_pkg;

  function automatic int calc_chk_w(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p = p + 1;
    return p;
  endfunction

  localparam int DATA_W    = 64;
  localparam int P_W       = calc_chk_w(DATA_W);
  localparam int CW_W      = DATA_W + P_W + 1;
  localparam int SEL_W     = $clog2(DATA_W);
  localparam int CHK_SEL_W = $clog2(P_W + 1);

  typedef enum logic [1:0] {
    INJ_OFF = 2'd0,
    INJ_ONE = 2'd1,
    INJ_TWO = 2'd2,
    INJ_CHK = 2'd3
  } inj_mode_e;

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // data index held at codeword position p, or -1 for check/parity slots
  function automatic int pos_to_idx(input int p);
    int n;
    int res;
    res = -1;
    if (p >= 3 && !is_pow2(p)) begin
      n = 0;
      for (int q = 1; q <= p; q++) begin
        if (is_pow2(q)) n = n + 1;
      end
      res = p - 1 - n;
    end
    return res;
  endfunction

  function automatic int data_pos(input int idx);
    int res;
    res = 0;
    for (int p = 3; p < CW_W; p++) begin
      if (pos_to_idx(p) == idx) res = p;
    end
    return res;
  endfunction

  // positions covered by position check bit k
  function automatic logic [CW_W-1:0] cover_mask(input int k);
    logic [CW_W-1:0] m;
    m = '0;
    for (int p = 1; p < CW_W; p++) begin
      m[p] = ((p >> k) & 1) != 0;
    end
    return m;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  output logic [CW_W-1:0]   cw_out
);

  logic [CW_W-1:0] scat;

  for (genvar p = 0; p < CW_W; p++) begin : g_scat
    localparam int IDX = pos_to_idx(p);
    if (IDX >= 0) begin : g_data
      assign scat[p] = data_in[IDX];
    end else begin : g_hole
      assign scat[p] = 1'b0;
    end
  end

  always_comb begin
    cw_out = scat;
    for (int k = 0; k < P_W; k++) begin
      cw_out[1 << k] = ^(scat & cover_mask(k));
    end
    cw_out[0] = ^cw_out[CW_W-1:1];
  end

endmodule

// File: rtl/secded_inject.sv
module secded_inject
  import secded_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  inj_mode_e            mode,
  input  logic [SEL_W-1:0]     sel_a,
  input  logic [SEL_W-1:0]     sel_b,
  input  logic [CW_W-1:0]      cw_in,
  output logic [CW_W-1:0]      cw_out
);

  logic [CW_W-1:0] flip;
  logic            data_mode;

  assign data_mode = (mode == INJ_ONE) || (mode == INJ_TWO);

  for (genvar p = 0; p < CW_W; p++) begin : g_flip
    localparam int IDX = pos_to_idx(p);
    if (IDX >= 0) begin : g_data
      assign flip[p] = (data_mode && (sel_a == SEL_W'(IDX))) ^
                       ((mode == INJ_TWO) && (sel_b == SEL_W'(IDX)));
    end else if (p == 0) begin : g_par
      assign flip[p] = (mode == INJ_CHK) && (sel_a[CHK_SEL_W-1:0] == CHK_SEL_W'(P_W));
    end else if (is_pow2(p)) begin : g_chk
      assign flip[p] = (mode == INJ_CHK) && (sel_a[CHK_SEL_W-1:0] == CHK_SEL_W'($clog2(p)));
    end else begin : g_none
      assign flip[p] = 1'b0;
    end
  end

  assign cw_out = cw_in ^ flip;

  AST_INJ_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    $countones(cw_out ^ cw_in) <= 2);  // R8
  AST_INJ_OFF_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (mode == INJ_OFF) |-> (cw_out == cw_in));  // R8

endmodule

// File: rtl/secded_ram.sv
module secded_ram #(
  parameter int WIDTH  = 72,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [CW_W-1:0]   cw_in,
  output logic [DATA_W-1:0] data_out,
  output logic              single_err,
  output logic              double_err
);

  logic [P_W-1:0]  syn;
  logic            par_bad;
  logic            in_range;
  logic [CW_W-1:0] fix;
  logic [CW_W-1:0] fixed_cw;

  always_comb begin
    for (int k = 0; k < P_W; k++) begin
      syn[k] = ^(cw_in & cover_mask(k));
    end
  end

  assign par_bad    = ^cw_in;
  assign in_range   = int'(syn) < CW_W;
  assign single_err = par_bad && in_range;
  assign double_err = (!par_bad && (syn != '0)) || (par_bad && !in_range);

  for (genvar p = 0; p < CW_W; p++) begin : g_fix
    if (p == 0) begin : g_par
      assign fix[p] = 1'b0;
    end else begin : g_pos
      assign fix[p] = single_err && (syn == P_W'(p));
    end
  end

  assign fixed_cw = cw_in ^ fix;

  for (genvar i = 0; i < DATA_W; i++) begin : g_out
    localparam int POS = data_pos(i);
    assign data_out[i] = fixed_cw[POS];
  end

endmodule

// File: rtl/secded_mem.sv
module secded_mem
  import secded_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [63:0]       wr_data,
  input  logic [1:0]        inj_mode,
  input  logic [5:0]        inj_sel_a,
  input  logic [5:0]        inj_sel_b,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic              err_single,
  output logic              err_double,
  output logic [ADDR_W-1:0] err_addr
);

  logic [CW_W-1:0]   enc_cw;
  logic [CW_W-1:0]   store_cw;
  logic [CW_W-1:0]   ram_cw;
  logic [DATA_W-1:0] dec_data;
  logic              dec_single;
  logic              dec_double;
  logic              rd_pend;
  logic [ADDR_W-1:0] addr_q;
  inj_mode_e         mode_e;

  assign mode_e = inj_mode_e'(inj_mode);

  secded_enc u_enc (
    .data_in (wr_data),
    .cw_out  (enc_cw)
  );

  secded_inject u_inj (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_e),
    .sel_a  (inj_sel_a),
    .sel_b  (inj_sel_b),
    .cw_in  (enc_cw),
    .cw_out (store_cw)
  );

  secded_ram #(.WIDTH(CW_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (store_cw),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (ram_cw)
  );

  secded_dec u_dec (
    .cw_in      (ram_cw),
    .data_out   (dec_data),
    .single_err (dec_single),
    .double_err (dec_double)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      addr_q  <= '0;
    end else begin
      rd_pend <= rd_en;
      if (rd_en) addr_q <= rd_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      err_single <= 1'b0;
      err_double <= 1'b0;
      err_addr   <= '0;
    end else begin
      rd_valid   <= rd_pend;
      err_single <= rd_pend && dec_single;
      err_double <= rd_pend && dec_double;
      if (rd_pend) rd_data <= dec_data;
      if (rd_pend && (dec_single || dec_double)) err_addr <= addr_q;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ##2 rd_valid);  // R1
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(err_single && err_double));  // R7
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (err_single || err_double) |-> rd_valid);  // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_data));  // R7
  AST_ERRADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(err_single || err_double) |-> $stable(err_addr));  // R6
  AST_ERRADDR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (err_single || err_double) |-> (err_addr == $past(rd_addr, 2)));  // R6

endmodule

// File: tb/secded_mem_bench.sv
module secded_mem_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int WATCHDOG_CYCLES = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [63:0]   wr_data = '0;
  logic [1:0]    inj_mode = 2'd0;
  logic [5:0]    inj_sel_a = '0;
  logic [5:0]    inj_sel_b = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid;
  logic [63:0]   rd_data;
  logic          err_single;
  logic          err_double;
  logic [AW-1:0] err_addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  secded_mem #(.ADDR_W(AW)) u_secded_mem (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .inj_mode   (inj_mode),
    .inj_sel_a  (inj_sel_a),
    .inj_sel_b  (inj_sel_b),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .err_single (err_single),
    .err_double (err_double),
    .err_addr   (err_addr)
  );

  function automatic logic [63:0] pat(input int n);
    logic [63:0] v;
    v = 64'h9E37_79B9_7F4A_7C15 * 64'(n + 1);
    return v ^ {32'(n), ~32'(n)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d,
                          input logic [1:0] m, input logic [5:0] sa, input logic [5:0] sb);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    inj_mode = m; inj_sel_a = sa; inj_sel_b = sb;
    @(negedge clk);
    wr_en = 1'b0; inj_mode = 2'd0;
  endtask

  // issues a read; returns at the negedge after results are registered
  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid == 1'b0, "R1", "valid one cycle early", 64'(rd_valid), 64'd0);
    @(negedge clk);
  endtask

  task automatic expect_result(input string req, input logic [63:0] d,
                               input bit s, input bit db, input logic [AW-1:0] ea);
    check(rd_valid == 1'b1, req, "rd_valid", 64'(rd_valid), 64'd1);
    check(rd_data == d, req, "rd_data", rd_data, d);
    check(err_single == s, req, "err_single", 64'(err_single), 64'(s));
    check(err_double == db, req, "err_double", 64'(err_double), 64'(db));
    check(err_addr == ea, req, "err_addr", 64'(err_addr), 64'(ea));
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] last_err;
    logic [63:0]   held;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(rd_valid == 1'b0, "R9", "rd_valid", 64'(rd_valid), 64'd0);
    check(err_single == 1'b0, "R9", "err_single", 64'(err_single), 64'd0);
    check(err_double == 1'b0, "R9", "err_double", 64'(err_double), 64'd0);
    check(err_addr == '0, "R9", "err_addr", 64'(err_addr), 64'd0);
    check(rd_data == '0, "R9", "rd_data", rd_data, 64'd0);
    rst = 1'b0;

    // R1 clean writes and reads; R8 mode 0 ignores selects
    for (int n = 0; n < 64; n++) begin
      do_write(AW'(n), pat(n), 2'd0, 6'(n), 6'(63 - n));
    end
    for (int n = 0; n < 64; n++) begin
      do_read(AW'(n));
      expect_result((n % 2 == 0) ? "R1" : "R8", pat(n), 1'b0, 1'b0, '0);
    end
    do_write(AW'(5), 64'd0, 2'd0, 6'd0, 6'd0);
    do_read(AW'(5));
    expect_result("R1", 64'd0, 1'b0, 1'b0, '0);
    do_write(AW'(6), '1, 2'd0, 6'd0, 6'd0);
    do_read(AW'(6));
    expect_result("R1", '1, 1'b0, 1'b0, '0);

    // R2 every data bit singly; R5 reread; R7 pulse; R6 hold
    for (int b = 0; b < 64; b++) begin
      logic [AW-1:0] a;
      a = AW'(63 - b);
      do_write(a, pat(b + 100), 2'd1, 6'(b), 6'(b ^ 5));
      do_read(a);
      expect_result("R2", pat(b + 100), 1'b1, 1'b0, a);
      @(negedge clk);
      check(err_single == 1'b0 && rd_valid == 1'b0, "R7", "flag pulse",
            64'({rd_valid, err_single}), 64'd0);
      check(rd_data == pat(b + 100), "R7", "data hold", rd_data, pat(b + 100));
      do_read(a);
      expect_result("R5", pat(b + 100), 1'b1, 1'b0, a);
      do_write(a ^ AW'(1), pat(b + 200), 2'd0, 6'd0, 6'd0);
      do_read(a ^ AW'(1));
      expect_result("R6", pat(b + 200), 1'b0, 1'b0, a);
    end

    // R3 each check bit, including overall parity (select 7)
    for (int c = 0; c < 8; c++) begin
      do_write(AW'(c + 10), pat(c + 300), 2'd3, 6'(c), 6'd0);
      do_read(AW'(c + 10));
      expect_result("R3", pat(c + 300), 1'b1, 1'b0, AW'(c + 10));
    end

    // R4 every unordered pair of data bits
    for (int x = 0; x < 64; x++) begin
      for (int y = x + 1; y < 64; y++) begin
        logic [AW-1:0] a;
        a = AW'(x + y);
        do_write(a, pat(x * 64 + y), 2'd2, 6'(x), 6'(y));
        do_read(a);
        check(err_double == 1'b1, "R4", "err_double", 64'(err_double), 64'd1);
        check(err_single == 1'b0, "R4", "err_single", 64'(err_single), 64'd0);
        check(err_addr == a, "R6", "err_addr", 64'(err_addr), 64'(a));
      end
    end

    // R8 equal selects in double mode cancel; R6 err_addr holds
    last_err = err_addr;
    do_write(AW'(40), pat(999), 2'd2, 6'd17, 6'd17);
    do_read(AW'(40));
    expect_result("R8", pat(999), 1'b0, 1'b0, last_err);
    held = rd_data;
    repeat (5) @(negedge clk);
    check(err_addr == last_err, "R6", "idle hold", 64'(err_addr), 64'(last_err));
    check(rd_data == held, "R7", "idle data hold", rd_data, held);

    // R9 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(err_addr == '0 && rd_data == '0, "R9", "reset clears",
          64'(err_addr) | rd_data, 64'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule